// File: doc/BRIEF.md
# Framed Parallel-to-Serial Word Sender

This block turns parallel words into a serial bit stream with a word boundary built into the stream. A rising edge on an asynchronous strobe takes a snapshot of the data bus. The word is held until the next frame begins. Each frame is `DATA_W + 2` bit times long and is sent least significant bit first. It opens with a two-bit marker that says whether the frame carries a word or is empty.

The bit rate comes from a bit-enable pulse in the bit-clock domain. The caller runs this pulse at the frame length times the word reference rate. Along with the serial data, the block sends a forwarded clock that changes level once for every bit. A receiver can sample on both edges of that clock.

The strobe may run slower than the frame rate. In that case, frames with no word go out with the empty marker and zero data bits. A second strobe that arrives while a word is still waiting is a loss of data. It sets a sticky overflow flag. While the lock/enable input is low, nothing is captured and nothing is sent.

Top module: `frame_serializer`

## Requirements
- R1: After a synchronous reset, `ser_data`, `ser_clk` and `overflow` are all 0.
- R2: While `lock_en` is high, every cycle with `bit_en` high puts out exactly one new bit on `ser_data`. In the following cycle `ser_clk` has changed level. A frame is `DATA_W + 2` such bits.
- R3: A frame that carries a word sends 1 as its first bit and 0 as its second. The word follows from bit 0 to bit `DATA_W-1`.
- R4: A frame with no word waiting sends 0 as its first bit and 1 as its second, and then `DATA_W` zero bits.
- R5: A rising edge of `strobe` captures `data_in`. `data_in` must stay stable for `SYNC_STAGES + 1` cycles after the edge. Each captured word is sent exactly once, in the order the words were captured, in the first frame that starts after the capture.
- R6: A strobe edge that arrives while a word is waiting and that word is not being loaded in the same cycle sets `overflow`. `overflow` stays set until reset. The new word is dropped and the waiting word is still sent.
- R7: While `lock_en` is low, strobe edges are ignored, any waiting word is discarded, `ser_data` is 0 and `ser_clk` holds its level. The first `bit_en` after `lock_en` rises starts a new frame.
- R8: A strobe held high captures only one word, however many frames it spans.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | Lock/enable from the clock controller |
| bit_en | input | 1 | One pulse per serial bit time |
| strobe | input | 1 | Asynchronous word strobe, rising edge captures |
| data_in | input | DATA_W | Parallel word |
| ser_data | output | 1 | Serial data, registered |
| ser_clk | output | 1 | Forwarded bit clock, one level change per bit |
| overflow | output | 1 | Sticky loss-of-data flag |

## Verification
The bench builds the block with `DATA_W = 8` and the default two-stage synchronizer. The frame is then ten bits long, which is twenty cycles with a bit-enable on every other cycle. Many frames fit in a short run, so the following cases can be reached in a modest number of cycles: empty frames between words, strobes spaced just longer than a frame, a strobe held across several frames, and a double strobe placed deliberately inside one frame. Because the monitor knows the bit position within the current frame, the bench can place the overflow pair between two frame starts every time, rather than relying on chance.

// File: rtl/word_ser_pkg.sv
package word_ser_pkg;
  localparam int MARK_W = 2;
  // marker bit 0 goes out first
  localparam logic [MARK_W-1:0] MARK_FULL  = 2'b01;
  localparam logic [MARK_W-1:0] MARK_EMPTY = 2'b10;
endpackage

// File: rtl/fs_strobe_sync.sv
module fs_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  localparam int CHAIN_W = SYNC_STAGES + 1;
  logic [CHAIN_W-1:0] chain;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-2:0], strobe};
  end

  assign rise = chain[CHAIN_W-2] & ~chain[CHAIN_W-1];

  // R8: one pulse per strobe edge
  p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fs_hold_reg.sv
module fs_hold_reg #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_en,
  input  logic              cap,
  input  logic              take,
  input  logic [DATA_W-1:0] data_in,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              overflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      data     <= '0;
      overflow <= 1'b0;
    end else if (!lock_en) begin
      full <= 1'b0;
    end else if (take) begin
      full <= cap;
      if (cap) data <= data_in;
    end else if (cap) begin
      if (full) overflow <= 1'b1;
      else begin
        full <= 1'b1;
        data <= data_in;
      end
    end
  end

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_drop_keeps_word_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_en && cap && full && !take) |=> (full && $stable(data)));
  p_unlocked_empty_r7: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> !full);
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter
  import word_ser_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_en,
  input  logic              bit_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              ser_data,
  output logic              ser_clk
);
  localparam int FRAME_W = DATA_W + MARK_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] load_val;

  assign take     = lock_en & bit_en & (cnt == '0);
  assign load_val = hold_full ? {hold_data, MARK_FULL}
                              : {{DATA_W{1'b0}}, MARK_EMPTY};

  always_ff @(posedge clk) begin
    if (rst || !lock_en) begin
      cnt      <= '0;
      sh       <= '0;
      ser_data <= 1'b0;
    end else if (bit_en) begin
      if (cnt == '0) begin
        ser_data <= load_val[0];
        sh       <= load_val >> 1;
      end else begin
        ser_data <= sh[0];
        sh       <= sh >> 1;
      end
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  ser_clk <= 1'b0;
    else if (lock_en && bit_en) ser_clk <= ~ser_clk;
  end

  p_toggle_per_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (lock_en && bit_en) |=> !$stable(ser_clk));
  p_clk_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> $stable(ser_clk));
  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> !ser_data);
  p_marker_first_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (ser_data == $past(hold_full)));
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_en,
  input  logic              bit_en,
  input  logic              strobe,
  input  logic [DATA_W-1:0] data_in,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              overflow
);
  logic              cap;
  logic              take;
  logic              full;
  logic [DATA_W-1:0] word;

  fs_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe(strobe), .rise(cap)
  );

  fs_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .lock_en(lock_en), .cap(cap), .take(take),
    .data_in(data_in), .full(full), .data(word), .overflow(overflow)
  );

  fs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .lock_en(lock_en), .bit_en(bit_en),
    .hold_full(full), .hold_data(word), .take(take),
    .ser_data(ser_data), .ser_clk(ser_clk)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!ser_data && !ser_clk && !overflow));
endmodule

// File: tb/frame_serializer_bench.sv
module frame_serializer_bench;
  localparam int DW = 8;
  localparam int FW = DW + 2;

  logic clk = 0, rst = 1, lock_en = 0, bit_en = 0, strobe = 0;
  logic [DW-1:0] data_in = '0;
  logic ser_data, ser_clk, overflow;

  frame_serializer #(.DATA_W(DW), .SYNC_STAGES(2)) u_frame_serializer (
    .clk(clk), .rst(rst), .lock_en(lock_en), .bit_en(bit_en),
    .strobe(strobe), .data_in(data_in),
    .ser_data(ser_data), .ser_clk(ser_clk), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int en_cnt = 0, tog_cnt = 0, empty_cnt = 0, data_cnt = 0, pushed = 0;
  int bitcnt = 0;
  logic prev_clk = 0;
  logic [FW-1:0] fr;
  logic [DW-1:0] expq[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bit-enable every other cycle, driven away from the edge
  always @(negedge clk) #1 bit_en = ~bit_en;

  always @(posedge clk) if (!rst && lock_en && bit_en) en_cnt++;

  // monitor: rebuild frames and compare against the scoreboard
  always @(negedge clk) begin
    if (rst) begin
      bitcnt = 0; prev_clk = 0;
    end else begin
      if (!lock_en) bitcnt = 0;
      else if (ser_clk != prev_clk) begin
        tog_cnt++;
        fr[bitcnt] = ser_data;
        bitcnt++;
        if (bitcnt == FW) begin
          bitcnt = 0;
          if (fr[1:0] == 2'b01) begin
            data_cnt++;
            if (expq.size() == 0)
              chk(0, "R5", "unexpected data frame", int'(fr[FW-1:2]), -1);
            else begin
              logic [DW-1:0] e;
              e = expq.pop_front();
              chk(fr[FW-1:2] == e, "R3", "frame word", int'(fr[FW-1:2]), int'(e));
            end
          end else if (fr[1:0] == 2'b10) begin
            empty_cnt++;
            chk(fr[FW-1:2] == '0, "R4", "empty frame data bits", int'(fr[FW-1:2]), 0);
          end else
            chk(0, "R3", "frame marker", int'(fr[1:0]), 1);
        end
      end
      prev_clk = ser_clk;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [DW-1:0] w, input int hi, input int gap);
    data_in = w; strobe = 1; expq.push_back(w); pushed++;
    cyc(hi); strobe = 0; cyc(gap);
  endtask

  initial begin
    cyc(5); rst = 0; cyc(1);
    chk({ser_data, ser_clk, overflow} == 3'b000, "R1", "reset outputs",
        int'({ser_data, ser_clk, overflow}), 0);

    lock_en = 1; cyc(70);
    chk(empty_cnt >= 2, "R4", "empty frames while idle", empty_cnt, 2);
    chk(tog_cnt == en_cnt, "R2", "toggles per bit-enable", tog_cnt, en_cnt);

    send(8'hA5, 4, 41); send(8'h01, 4, 41); send(8'h80, 4, 41); send(8'hFF, 4, 41);
    for (int i = 0; i < 4; i++) send(8'(8'h3C + i * 17), 4, 21);
    cyc(50);
    chk(expq.size() == 0, "R5", "words pending after spaced sends", expq.size(), 0);
    chk(data_cnt == pushed, "R5", "data frames sent once", data_cnt, pushed);
    chk(overflow == 1'b0, "R6", "no overflow on legal spacing", int'(overflow), 0);
    chk(tog_cnt == en_cnt, "R2", "toggles per bit-enable", tog_cnt, en_cnt);

    // R8: strobe held high over several frames
    data_in = 8'h5A; strobe = 1; expq.push_back(8'h5A); pushed++;
    cyc(70); strobe = 0; cyc(50);
    chk(data_cnt == pushed, "R8", "one capture for a long strobe", data_cnt, pushed);

    // R6: two edges inside one frame
    while (bitcnt != 2) @(negedge clk);
    #1;
    data_in = 8'hC3; strobe = 1; expq.push_back(8'hC3); pushed++;
    cyc(3); strobe = 0; cyc(3);
    data_in = 8'h77; strobe = 1; cyc(3); strobe = 0; cyc(60);
    chk(overflow == 1'b1, "R6", "overflow set", int'(overflow), 1);
    chk(data_cnt == pushed, "R6", "held word sent, dropped word not", data_cnt, pushed);
    cyc(40);
    chk(overflow == 1'b1, "R6", "overflow sticky", int'(overflow), 1);

    // R7: unlocked
    lock_en = 0; cyc(4);
    begin
      int t0, e0;
      t0 = tog_cnt; e0 = empty_cnt;
      chk(ser_data == 1'b0, "R7", "ser_data low when unlocked", int'(ser_data), 0);
      data_in = 8'h99; strobe = 1; cyc(10); strobe = 0; cyc(10);
      chk(tog_cnt == t0, "R7", "ser_clk holds when unlocked", tog_cnt, t0);
      lock_en = 1; cyc(80);
      chk(data_cnt == pushed, "R7", "no word captured while unlocked", data_cnt, pushed);
      chk(empty_cnt > e0, "R7", "framing restarts after lock", empty_cnt, e0 + 1);
    end
    chk(tog_cnt == en_cnt, "R2", "toggles per bit-enable", tog_cnt, en_cnt);
    chk(expq.size() == 0, "R5", "scoreboard drained", expq.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule